// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block sits between an internal 24-bit address bus and an external asynchronous DRAM. Each accepted request is classified as in-page or out-of-page against a single open-page tracker. The block then drives the row and column addresses on one shared address bus, generates active-low row and column strobes, and counts out the wait states selected by configuration codes. It ends every access with a one-cycle completion pulse. The open-page tracker covers all banks at once, so a change of bank, a change of page size, loss of bus mastership with strobe driving disabled, or page logic being switched off all close the page. When page logic is off, every access is a full row-then-column cycle and both strobes return high afterwards.

Requests use a valid/ready handshake. The requester raises `req_valid` with `req_addr` and `req_bank` and must hold all three unchanged until a cycle in which `req_ready` is also high; the request is taken on that clock edge. `req_ready` is low for the whole of an access and also while mastership is absent. The configuration inputs are plain levels. They are sampled on the accepting edge, and later changes do not affect the access in progress.

Top module: `dram_page_seq`

## Requirements
- R1: The page-size code gives the column width: 0 selects 9 bits, 1 selects 10, 2 selects 11, 3 selects 12. In a column cycle the address bus carries the request address bits below the column width, and all higher lines are zero.
- R2: In a row or precharge cycle, the lines below (24 − column width) carry the request address shifted right by the column width. Each remaining upper line i carries request address bit i.
- R3: An out-of-page access from the idle state is one row cycle (RAS low, CAS high) followed by N column cycles (RAS and CAS low). N is 4, 8, 11 or 15 for row-wait codes 0, 1, 2 and 3.
- R4: An in-page access is 2, 3, 4 or 5 column cycles (one plus 1, 2, 3 or 4 wait states) for column-wait codes 0, 1, 2 and 3. No row cycle is included.
- R5: An access is in-page when a page is open, its bank matches, its page-size code matches, and its address bits at and above the column width match the open page. During an in-page access RAS stays low throughout.
- R6: An out-of-page access that starts while a page is open begins with one precharge cycle (RAS and CAS high, row address driven) before the row cycle.
- R7: A request to a different bank than the open page is out-of-page, even when the address is the same.
- R8: With page logic disabled, every access is out-of-page and RAS returns high after it. Disabling page logic while a page is open closes it on the next edge, which raises RAS.
- R9: `ras_oe` and `cas_oe` are high when mastership is held or strobe driving is enabled. If mastership drops while strobe driving is disabled, the open page closes. With strobe driving enabled, the page stays open through the loss.
- R10: `done` is high for exactly the one cycle after the last column cycle. `req_ready` is high only in the idle state, or in the page-open state with page logic enabled, and in both cases only while mastership is held.
- R11: Wait codes, page-size code and page-enable are taken on the accepting edge. Changing them during an access does not alter that access's timing or addresses.
- R12: After reset, RAS and CAS are high, `done` is low, the address bus is zero and no page is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_addr | input | 24 | Internal word address of the request |
| req_bank | input | 2 | External bank the request targets |
| bus_master | input | 1 | High while this block owns the external bus |
| cfg_bme | input | 1 | Keep driving the strobes without mastership |
| cfg_page_en | input | 1 | Enable in-page detection |
| cfg_psize | input | 2 | Page-size code (column width 9 + code) |
| cfg_row_wait | input | 2 | Out-of-page wait code |
| cfg_col_wait | input | 2 | In-page wait code |
| dram_addr | output | 24 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ras_oe | output | 1 | Output enable for the row strobe |
| cas_oe | output | 1 | Output enable for the column strobe |
| done | output | 1 | One-cycle access-complete pulse |

## Verification
The properties assume that mastership is held from the accepting edge until the `done` pulse, since the block does not model an access aborted half-way. They also assume that a requester keeps `req_addr` and `req_bank` steady while it waits for `req_ready`. The stimulus changes `bus_master` only between accesses and holds request fields until acceptance. It drives every input half a clock away from the active edge. Configuration codes are deliberately changed in the middle of an access so that the latching can be seen.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int WAIT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPEN = 3'd1,
    ST_PRE  = 3'd2,
    ST_ROW  = 3'd3,
    ST_COL  = 3'd4
  } seq_state_t;

  // Column cycles following the row cycle of an out-of-page access
  function automatic logic [WAIT_W-1:0] row_cycles(input logic [1:0] code);
    case (code)
      2'd0:    return WAIT_W'(4);
      2'd1:    return WAIT_W'(8);
      2'd2:    return WAIT_W'(11);
      default: return WAIT_W'(15);
    endcase
  endfunction

  // Column cycles of an in-page access: one strobe cycle plus (code + 1) waits
  function automatic logic [WAIT_W-1:0] col_cycles(input logic [1:0] code);
    return WAIT_W'(code) + WAIT_W'(2);
  endfunction

endpackage

// File: rtl/dpg_addr_mux.sv
module dpg_addr_mux #(
  parameter int AW      = 24,
  parameter int COL_MIN = 9
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    psize,
  input  logic          sel_row,
  input  logic          sel_col,
  output logic [AW-1:0] bus
);
  localparam int SW = $clog2(AW + 1);
  localparam logic [AW-1:0] ALL1 = '1;

  logic [SW-1:0] cw;
  logic [AW-1:0] row_word, col_word;

  assign cw = SW'(COL_MIN) + SW'(psize);

  // Row: page bits moved to the bottom, top lines repeat the top address bits
  assign row_word = (addr >> cw) | (addr & ~(ALL1 >> cw));
  // Column: in-page offset only
  assign col_word = addr & ~(ALL1 << cw);

  always_comb begin
    if (sel_row)      bus = row_word;
    else if (sel_col) bus = col_word;
    else              bus = '0;
  end
endmodule

// File: rtl/dpg_page_tracker.sv
module dpg_page_tracker #(
  parameter int AW      = 24,
  parameter int BANK_W  = 2,
  parameter int COL_MIN = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [AW-1:0]     ld_addr,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [1:0]        ld_psize,
  input  logic [AW-1:0]     cmp_addr,
  input  logic [BANK_W-1:0] cmp_bank,
  input  logic [1:0]        cmp_psize,
  output logic              hit
);
  localparam int SW = $clog2(AW + 1);

  logic              open_vld;
  logic [AW-1:0]     open_addr;
  logic [BANK_W-1:0] open_bank;
  logic [1:0]        open_ps;
  logic [SW-1:0]     cw;

  assign cw  = SW'(COL_MIN) + SW'(cmp_psize);
  assign hit = open_vld && (open_bank == cmp_bank) && (open_ps == cmp_psize)
               && (((cmp_addr ^ open_addr) >> cw) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_vld  <= 1'b0;
      open_addr <= '0;
      open_bank <= '0;
      open_ps   <= '0;
    end else if (load) begin
      open_vld  <= 1'b1;
      open_addr <= ld_addr;
      open_bank <= ld_bank;
      open_ps   <= ld_psize;
    end else if (clr) begin
      open_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/dpg_wait_timer.sv
module dpg_wait_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int AW      = 24,
  parameter int BANK_W  = 2,
  parameter int COL_MIN = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              bus_master,
  input  logic              cfg_bme,
  input  logic              cfg_page_en,
  input  logic [1:0]        cfg_psize,
  input  logic [1:0]        cfg_row_wait,
  input  logic [1:0]        cfg_col_wait,
  output logic [AW-1:0]     dram_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              ras_oe,
  output logic              cas_oe,
  output logic              done
);
  localparam int WW = WAIT_W;

  seq_state_t st, st_nx;

  logic              bm_q;
  logic [AW-1:0]     a_addr;
  logic [BANK_W-1:0] a_bank;
  logic              a_pe;
  logic [1:0]        a_ps, a_rw;

  logic          page_hit, wt_last, wt_load;
  logic [WW-1:0] wt_val;
  logic          loss, accept, close_open, end_acc;

  assign loss       = bm_q & ~bus_master & ~cfg_bme;
  assign req_ready  = bus_master & ((st == ST_IDLE) | ((st == ST_OPEN) & cfg_page_en));
  assign accept     = req_valid & req_ready;
  assign close_open = (st == ST_OPEN) & (loss | ~cfg_page_en);
  assign end_acc    = (st == ST_COL) & wt_last;

  dpg_page_tracker #(.AW(AW), .BANK_W(BANK_W), .COL_MIN(COL_MIN)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .clr      (close_open | (end_acc & ~a_pe)),
    .load     (end_acc & a_pe),
    .ld_addr  (a_addr),
    .ld_bank  (a_bank),
    .ld_psize (a_ps),
    .cmp_addr (req_addr),
    .cmp_bank (req_bank),
    .cmp_psize(cfg_psize),
    .hit      (page_hit)
  );

  dpg_wait_timer #(.CW(WW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (wt_load),
    .load_val(wt_val),
    .last    (wt_last)
  );

  dpg_addr_mux #(.AW(AW), .COL_MIN(COL_MIN)) u_mux (
    .addr   (a_addr),
    .psize  (a_ps),
    .sel_row((st == ST_PRE) | (st == ST_ROW)),
    .sel_col(st == ST_COL),
    .bus    (dram_addr)
  );

  always_comb begin
    st_nx   = st;
    wt_load = 1'b0;
    wt_val  = row_cycles(a_rw);
    unique case (st)
      ST_IDLE: if (accept) st_nx = ST_ROW;
      ST_OPEN: begin
        if (close_open) begin
          st_nx = ST_IDLE;
        end else if (accept) begin
          if (page_hit) begin
            st_nx   = ST_COL;
            wt_load = 1'b1;
            wt_val  = col_cycles(cfg_col_wait);
          end else begin
            st_nx = ST_PRE;
          end
        end
      end
      ST_PRE:  st_nx = ST_ROW;
      ST_ROW: begin
        st_nx   = ST_COL;
        wt_load = 1'b1;
      end
      ST_COL:  if (wt_last) st_nx = a_pe ? ST_OPEN : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      bm_q   <= 1'b0;
      done   <= 1'b0;
      a_addr <= '0;
      a_bank <= '0;
      a_pe   <= 1'b0;
      a_ps   <= '0;
      a_rw   <= '0;
    end else begin
      st   <= st_nx;
      bm_q <= bus_master;
      done <= end_acc;
      if (accept) begin
        a_addr <= req_addr;
        a_bank <= req_bank;
        a_pe   <= cfg_page_en;
        a_ps   <= cfg_psize;
        a_rw   <= cfg_row_wait;
      end
    end
  end

  assign ras_n  = ~((st == ST_OPEN) | (st == ST_ROW) | (st == ST_COL));
  assign cas_n  = ~(st == ST_COL);
  assign ras_oe = cfg_bme | bus_master;
  assign cas_oe = cfg_bme | bus_master;

endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic bus_master,
  input logic cfg_bme,
  input logic ras_n,
  input logic cas_n,
  input logic ras_oe,
  input logic cas_oe,
  input logic done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_DONE_AFTER_COL: assert property (@(posedge clk) disable iff (rst) done |-> $past(!cas_n)); // R4
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst) !cas_n |-> !ras_n); // R5
  AST_ROW_BEFORE_COL: assert property (@(posedge clk) disable iff (rst) $fell(ras_n) |-> cas_n); // R6
  AST_READY_NO_CAS: assert property (@(posedge clk) disable iff (rst) req_ready |-> cas_n); // R10
  AST_READY_MASTER: assert property (@(posedge clk) disable iff (rst) req_ready |-> bus_master); // R10
  AST_OE_MASTER: assert property (@(posedge clk) disable iff (rst) (bus_master || cfg_bme) |-> (ras_oe && cas_oe)); // R9
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst) (!bus_master && !cfg_bme) |-> (!ras_oe && !cas_oe)); // R9
endmodule

bind dram_page_seq dram_page_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .bus_master(bus_master),
  .cfg_bme   (cfg_bme),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .ras_oe    (ras_oe),
  .cas_oe    (cas_oe),
  .done      (done)
);

// File: tb/dram_page_seq_test.sv
module dram_page_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_bank = '0;
  logic        bus_master = 1'b1;
  logic        cfg_bme = 1'b0;
  logic        cfg_page_en = 1'b0;
  logic [1:0]  cfg_psize = '0;
  logic [1:0]  cfg_row_wait = '0;
  logic [1:0]  cfg_col_wait = '0;
  logic [23:0] dram_addr;
  logic        ras_n, cas_n, ras_oe, cas_oe, done;

  dram_page_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bank(req_bank), .bus_master(bus_master),
    .cfg_bme(cfg_bme), .cfg_page_en(cfg_page_en), .cfg_psize(cfg_psize),
    .cfg_row_wait(cfg_row_wait), .cfg_col_wait(cfg_col_wait),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n),
    .ras_oe(ras_oe), .cas_oe(cas_oe), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    run = 1'b0;
  bit    finished = 1'b0;
  string cur = "R12";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, expv);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct packed {
    logic [23:0] a;
    logic        ras;
    logic        cas;
    logic        dn;
    logic        idl;
  } ent_t;

  ent_t        q[$];
  ent_t        exp_e;
  bit          m_open = 1'b0;
  logic [23:0] m_addr = '0;
  logic [1:0]  m_bank = '0;
  logic [1:0]  m_ps = '0;
  bit          prev_bm = 1'b0;
  int          row_tab[4] = '{4, 8, 11, 15};

  function automatic ent_t mk(input logic [23:0] a, input logic r, input logic c,
                              input logic d, input logic i);
    ent_t e;
    e.a = a; e.ras = r; e.cas = c; e.dn = d; e.idl = i;
    return e;
  endfunction

  function automatic logic [23:0] m_row(input logic [23:0] a, input int w);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) begin
      if (i < 24 - w) r[i] = a[i + w];
      else            r[i] = a[i];
    end
    return r;
  endfunction

  function automatic logic [23:0] m_col(input logic [23:0] a, input int w);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < w) ? a[i] : 1'b0;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_open  = 1'b0;
      prev_bm = 1'b0;
      exp_e   = mk('0, 1'b1, 1'b1, 1'b0, 1'b1);
    end else begin
      bit lossv, acc, hit;
      int w;
      lossv = prev_bm && !bus_master && !cfg_bme;
      acc   = exp_e.idl && bus_master && (!m_open || cfg_page_en) && req_valid;
      if (exp_e.idl && m_open && (lossv || !cfg_page_en)) begin
        m_open = 1'b0;
      end else if (acc) begin
        w   = 9 + int'(cfg_psize);
        hit = m_open && cfg_page_en && (req_bank == m_bank) && (cfg_psize == m_ps)
              && ((req_addr >> w) == (m_addr >> w));
        if (hit) begin
          repeat (int'(cfg_col_wait) + 2) q.push_back(mk(m_col(req_addr, w), 1'b0, 1'b0, 1'b0, 1'b0));
        end else begin
          if (m_open) q.push_back(mk(m_row(req_addr, w), 1'b1, 1'b1, 1'b0, 1'b0));
          q.push_back(mk(m_row(req_addr, w), 1'b0, 1'b1, 1'b0, 1'b0));
          repeat (row_tab[cfg_row_wait]) q.push_back(mk(m_col(req_addr, w), 1'b0, 1'b0, 1'b0, 1'b0));
        end
        q.push_back(mk('0, !cfg_page_en, 1'b1, 1'b1, 1'b1));
        m_open = cfg_page_en;
        m_addr = req_addr;
        m_bank = req_bank;
        m_ps   = cfg_psize;
      end
      prev_bm = bus_master;
      if (q.size() > 0) exp_e = q.pop_front();
      else              exp_e = mk('0, !m_open, 1'b1, 1'b0, 1'b1);
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (run && !rst) begin
      bit rdy;
      rdy = exp_e.idl && bus_master && (!m_open || cfg_page_en);
      chk(dram_addr == exp_e.a, cur, "dram_addr", dram_addr, exp_e.a);
      chk(ras_n == exp_e.ras, cur, "ras_n", ras_n, exp_e.ras);
      chk(cas_n == exp_e.cas, cur, "cas_n", cas_n, exp_e.cas);
      chk(done == exp_e.dn, cur, "done (R10)", done, exp_e.dn);
      chk(req_ready == rdy, cur, "req_ready (R10)", req_ready, rdy);
      chk(ras_oe == (cfg_bme | bus_master) && cas_oe == (cfg_bme | bus_master), cur,
          "oe (R9)", {ras_oe, cas_oe}, {2{cfg_bme | bus_master}});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input logic [23:0] a, input logic [1:0] b);
    bit r;
    @(negedge clk); #1;
    req_addr = a; req_bank = b; req_valid = 1'b1;
    forever begin
      #1 r = req_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 64) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic access(input logic [23:0] a, input logic [1:0] b);
    issue(a, b);
    wait_done();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset values
    chk(ras_n == 1'b1 && cas_n == 1'b1, "R12", "strobes in reset", {ras_n, cas_n}, 2'b11);
    chk(done == 1'b0, "R12", "done in reset", done, 0);
    chk(dram_addr == '0, "R12", "addr in reset", dram_addr, 0);
    #1 rst = 1'b0;
    run = 1'b1;
    idle(2);

    // R8: page logic disabled, full cycles each time
    cur = "R8";
    access(24'h123456, 2'd0);
    access(24'h123457, 2'd0);

    // R2: row mapping with 10 column bits, row-wait code 1
    cur = "R2";
    @(negedge clk); #1 cfg_psize = 2'd1; cfg_row_wait = 2'd1;
    access(24'hABCDEF, 2'd1);

    // R3: out-of-page from idle with page logic on, code 2
    cur = "R3";
    @(negedge clk); #1 cfg_page_en = 1'b1; cfg_row_wait = 2'd2;
    access(24'h100200, 2'd0);

    // R5 / R4: hits with each column-wait code
    cur = "R5";
    @(negedge clk); #1 cfg_col_wait = 2'd0;
    access(24'h100201, 2'd0);
    cur = "R4";
    for (int c = 1; c < 4; c++) begin
      @(negedge clk); #1 cfg_col_wait = 2'(c);
      access(24'h1003F0 + 24'(c), 2'd0);
    end

    // R6: miss from an open page, longest row wait
    cur = "R6";
    @(negedge clk); #1 cfg_row_wait = 2'd3;
    access(24'h200000, 2'd0);

    // R7: same address, other bank
    cur = "R7";
    access(24'h200000, 2'd2);

    // R1: page-size changes and column widths
    cur = "R1";
    @(negedge clk); #1 cfg_psize = 2'd3; cfg_row_wait = 2'd0;
    access(24'h200000, 2'd2);
    access(24'h200FFF, 2'd2);
    @(negedge clk); #1 cfg_psize = 2'd2;
    access(24'hF00123, 2'd1);
    access(24'hF007FF, 2'd1);
    @(negedge clk); #1 cfg_psize = 2'd0;
    access(24'h5A5A5A, 2'd3);
    access(24'h5A5BFF, 2'd3);

    // R9: mastership loss with and without strobe driving
    cur = "R9";
    @(negedge clk); #1 bus_master = 1'b0;
    idle(3);
    @(negedge clk); #1 bus_master = 1'b1;
    access(24'h5A5A00, 2'd3);
    @(negedge clk); #1 cfg_bme = 1'b1;
    @(negedge clk); #1 bus_master = 1'b0;
    idle(3);
    @(negedge clk); #1 bus_master = 1'b1;
    access(24'h5A5A11, 2'd3);
    @(negedge clk); #1 cfg_bme = 1'b0;

    // R11: configuration changed mid-access
    cur = "R11";
    issue(24'h777000, 2'd1);
    @(negedge clk); #1 cfg_row_wait = 2'd3; cfg_psize = 2'd3; cfg_col_wait = 2'd0;
    wait_done();
    @(negedge clk); #1 cfg_psize = 2'd0; cfg_row_wait = 2'd1;
    access(24'h777011, 2'd1);

    // R10: back-to-back requests under back-pressure
    cur = "R10";
    issue(24'h300000, 2'd0);
    issue(24'h300010, 2'd0);
    wait_done();
    @(negedge clk);

    // R8: page logic switched off while a page is open
    cur = "R8";
    @(negedge clk); #1 cfg_page_en = 1'b0;
    idle(3);
    @(negedge clk); #1 cfg_page_en = 1'b1;
    access(24'h300020, 2'd0);
    idle(4);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule